// File: doc/BRIEF.md
# Nibble-Loaded Auto-Increment Static RAM Bridge

This block lets a host with only an 8-bit parallel bus, two active-low strobes and a single select line reach a byte-wide asynchronous static RAM with a wide address space. The select line chooses between two modes. With select high, each write strobe hands over one 4-bit slice of an address. The slices enter a shift register, most significant first, so six of them form a 24-bit byte address. With select low, every read or write strobe moves one byte at the internal pointer and then moves the pointer to the next byte.

The host strobes run asynchronously to the block clock. They are synchronized, and each action fires once, on the detected falling edge of a strobe. The RAM controls follow the strobe until it is released. A slow memory is therefore served by simply holding the strobe longer, so read and write strobes can have different widths. After it loads a new address, the host usually issues one read whose byte it throws away. That read advances the pointer like any other.

Top module: `nsb_sram_bridge`

## Requirements
- R1: During and immediately after reset, the pointer is 0. The RAM enable, output-enable and write-enable are all high (inactive), and neither the host-side nor the RAM-side data driver is enabled.
- R2: With select high, a write strobe shifts the pointer left by 4 bits and puts host_d_i[3:0] into bits [3:0]. Bits [7:4] are ignored. Any number of slices may be written, and the last NIBBLES of them set the address, most significant first.
- R3: With select low, a read strobe puts the pointer on sram_a and drives sram_ce_n and sram_oe_n low until the strobe is released. host_d_o carries sram_dq_i during this time, and the pointer then advances by one. A read issued right after an address load is an ordinary read and also advances the pointer.
- R4: With select low, a write strobe puts the pointer on sram_a and host_d_i[7:0] on sram_dq_o. It drives sram_ce_n and sram_we_n low until the strobe is released, and the pointer then advances by one.
- R5: Incrementing the pointer from its all-ones value gives 0.
- R6: A strobe causes exactly one action however long it is held low. If both strobes fall in the same cycle, the write is taken and the read is dropped.
- R7: host_d_oe is high only while host_rd_n is low and host_sel is low. A read strobe with select high has no effect on the RAM controls or the pointer.
- R8: sram_dq_oe is high whenever sram_we_n is low, and for one cycle after sram_we_n rises. sram_dq_oe and a low sram_oe_n never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | 1 = address-slice mode, 0 = data mode |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_d_i | input | 8 | Byte from host |
| host_d_o | output | 8 | Byte to host |
| host_d_oe | output | 1 | Host-side bus driver enable |
| sram_a | output | NIB_W*NIBBLES | RAM byte address |
| sram_dq_i | input | 8 | Byte from RAM |
| sram_dq_o | output | 8 | Byte to RAM |
| sram_dq_oe | output | 1 | RAM-side bus driver enable |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |

## Verification
The bench builds the bridge with NIBBLES=3, which gives a 12-bit, 4096-byte space, and with two synchronizer stages. At that size every location can be written and then read back in one run. The pointer visibly wraps from 0xFFF to 0 at the end of each sweep. An over-long slice sequence of seven nibbles shows that only the last three take effect. Long strobes, address-mode reads and simultaneous strobes are then applied, and their effect on the pointer is observed through the address of the next access.

// File: rtl/nsb_pkg.sv
package nsb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_HOLD  = 2'd3
  } nsb_phase_e;

endpackage

// File: rtl/nsb_sync.sv
module nsb_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] fall
);

  logic [W-1:0] st [STAGES];
  logic [W-1:0] prev;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[0] <= RST_VAL;
          else        st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st[gi] <= RST_VAL;
          else        st[gi] <= st[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= st[STAGES-1];
  end

  assign q    = st[STAGES-1];
  assign fall = prev & ~st[STAGES-1];

endmodule

// File: rtl/nsb_ptr.sv
module nsb_ptr #(
  parameter int NIB_W   = 4,
  parameter int NIBBLES = 6,
  localparam int ADDR_W = NIB_W * NIBBLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [NIB_W-1:0]  nib,
  input  logic              inc_en,
  output logic [ADDR_W-1:0] ptr
);

  function automatic logic [ADDR_W-1:0] slice_in(input logic [ADDR_W-1:0] cur,
                                                 input logic [NIB_W-1:0]  n);
    return {cur[ADDR_W-NIB_W-1:0], n};
  endfunction

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (shift_en) ptr <= slice_in(ptr, nib);
    else if (inc_en)   ptr <= step(ptr);
  end

endmodule

// File: rtl/nsb_seq.sv
module nsb_seq
  import nsb_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              rd_s,
  input  logic              wr_s,
  input  logic              rd_fall,
  input  logic              wr_fall,
  input  logic [7:0]        host_byte,
  input  logic [ADDR_W-1:0] ptr,
  output logic              ev_rd,
  output logic              ev_wr,
  output logic              ev_nib,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [7:0]        wr_byte,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dq_oe
);

  nsb_phase_e phase, phase_nx;
  logic       idle;

  assign idle   = (phase == PH_IDLE);
  assign ev_nib = idle & wr_fall & sel_s;
  assign ev_wr  = idle & wr_fall & ~sel_s;
  assign ev_rd  = idle & rd_fall & ~wr_fall & ~sel_s;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:  if (ev_wr) phase_nx = PH_WRITE;
                else if (ev_rd) phase_nx = PH_READ;
      PH_READ:  if (rd_s) phase_nx = PH_IDLE;
      PH_WRITE: if (wr_s) phase_nx = PH_HOLD;
      PH_HOLD:  phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      acc_addr <= '0;
      wr_byte  <= '0;
    end else begin
      phase <= phase_nx;
      if (ev_rd || ev_wr) acc_addr <= ptr;
      if (ev_wr)          wr_byte  <= host_byte;
    end
  end

  assign ce_n  = idle;
  assign oe_n  = (phase != PH_READ);
  assign we_n  = (phase != PH_WRITE);
  assign dq_oe = (phase == PH_WRITE) || (phase == PH_HOLD);

endmodule

// File: rtl/nsb_sram_bridge.sv
module nsb_sram_bridge #(
  parameter int NIB_W       = 4,
  parameter int NIBBLES     = 6,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = NIB_W * NIBBLES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [7:0]        host_d_i,
  output logic [7:0]        host_d_o,
  output logic              host_d_oe,
  output logic [ADDR_W-1:0] sram_a,
  input  logic [7:0]        sram_dq_i,
  output logic [7:0]        sram_dq_o,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);

  logic [2:0]        raw_v, sync_v, fall_v;
  logic              sel_s, rd_s, wr_s, rd_fall, wr_fall;
  logic              ev_rd, ev_wr, ev_nib;
  logic [ADDR_W-1:0] ptr;

  assign raw_v   = {host_sel, host_wr_n, host_rd_n};
  assign sel_s   = sync_v[2];
  assign wr_s    = sync_v[1];
  assign rd_s    = sync_v[0];
  assign wr_fall = fall_v[1];
  assign rd_fall = fall_v[0];

  nsb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_v),
    .q    (sync_v),
    .fall (fall_v)
  );

  nsb_ptr #(.NIB_W(NIB_W), .NIBBLES(NIBBLES)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(ev_nib),
    .nib     (host_d_i[NIB_W-1:0]),
    .inc_en  (ev_rd | ev_wr),
    .ptr     (ptr)
  );

  nsb_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_s    (sel_s),
    .rd_s     (rd_s),
    .wr_s     (wr_s),
    .rd_fall  (rd_fall),
    .wr_fall  (wr_fall),
    .host_byte(host_d_i),
    .ptr      (ptr),
    .ev_rd    (ev_rd),
    .ev_wr    (ev_wr),
    .ev_nib   (ev_nib),
    .acc_addr (sram_a),
    .wr_byte  (sram_dq_o),
    .ce_n     (sram_ce_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n),
    .dq_oe    (sram_dq_oe)
  );

  assign host_d_oe = ~host_rd_n & ~host_sel;
  assign host_d_o  = sram_dq_i;

endmodule

// File: rtl/nsb_chk.sv
module nsb_chk #(
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_rd,
  input logic              ev_wr,
  input logic              ev_nib,
  input logic [ADDR_W-1:0] ptr,
  input logic [7:0]        host_d_i,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe
);

  p_slice_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nib |=> ptr == {$past(ptr[ADDR_W-NIB_W-1:0]), $past(host_d_i[NIB_W-1:0])});

  p_step_after_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd || ev_wr) |=> ptr == ADDR_W'($past(ptr) + ADDR_W'(1)));

  p_ptr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rd || ev_wr || ev_nib) |=> $stable(ptr));

  p_single_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rd, ev_wr, ev_nib}));

  p_read_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |=> !ev_rd);

  p_enable_with_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_oe_n || !sram_we_n) |-> !sram_ce_n);

  p_drive_during_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_dq_oe);

  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sram_dq_oe && !sram_oe_n));

endmodule

bind nsb_sram_bridge nsb_chk #(.NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_rd     (ev_rd),
  .ev_wr     (ev_wr),
  .ev_nib    (ev_nib),
  .ptr       (ptr),
  .host_d_i  (host_d_i),
  .sram_ce_n (sram_ce_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .sram_dq_oe(sram_dq_oe)
);

// File: tb/sim_nsb_sram_bridge.sv
module sim_nsb_sram_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int NIB_W      = 4;
  localparam int NIBBLES    = 3;
  localparam int AW         = NIB_W * NIBBLES;
  localparam int DEPTH      = 1 << AW;
  localparam int HOLD       = 5;
  localparam int GAP        = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_sel = 1'b1;
  logic          host_rd_n = 1'b1;
  logic          host_wr_n = 1'b1;
  logic [7:0]    host_d_i = '0;
  logic [7:0]    host_d_o;
  logic          host_d_oe;
  logic [AW-1:0] sram_a;
  logic [7:0]    sram_dq_i;
  logic [7:0]    sram_dq_o;
  logic          sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  nsb_sram_bridge #(.NIB_W(NIB_W), .NIBBLES(NIBBLES), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_d_i(host_d_i), .host_d_o(host_d_o),
    .host_d_oe(host_d_oe), .sram_a(sram_a), .sram_dq_i(sram_dq_i),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
  );

  // asynchronous byte-wide memory model
  assign sram_dq_i = (!sram_ce_n && !sram_oe_n) ? mem[sram_a] : 8'h00;
  always @(posedge clk) if (!sram_ce_n && !sram_we_n) mem[sram_a] <= sram_dq_o;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) + (a >> 8) + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h, expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put_slice(input logic [3:0] n);
    host_sel = 1'b1; host_d_i = {4'hA, n}; host_wr_n = 1'b0;
    wait_neg(HOLD);
    chk(sram_we_n && sram_ce_n, "R2", "ram idle during slice write", sram_we_n, 1);
    host_wr_n = 1'b1;
    wait_neg(GAP);
  endtask

  task automatic load_addr(input int a);
    for (int i = NIBBLES - 1; i >= 0; i--) put_slice(4'((a >> (4 * i)) & 15));
  endtask

  task automatic data_wr(input logic [7:0] b, input int exp_a, input string req);
    host_sel = 1'b0; host_d_i = b; host_wr_n = 1'b0;
    wait_neg(HOLD);
    chk(int'(sram_a) == exp_a, req, "write address", sram_a, exp_a);
    chk(!sram_we_n && !sram_ce_n && sram_dq_o == b, "R4", "write strobe/data",
        sram_dq_o, b);
    host_wr_n = 1'b1;
    wait_neg(GAP);
  endtask

  task automatic data_rd(input int exp_a, input string req, input int hold);
    host_sel = 1'b0; host_rd_n = 1'b0;
    wait_neg(hold);
    chk(int'(sram_a) == exp_a, req, "read address", sram_a, exp_a);
    chk(!sram_oe_n && !sram_ce_n && host_d_oe && host_d_o == pat(exp_a), "R3",
        "read data", host_d_o, pat(exp_a));
    host_rd_n = 1'b1;
    wait_neg(GAP);
  endtask

  // continuous monitors on driver rules
  always @(negedge clk) begin
    if (rst_n) begin
      if (!sram_we_n) chk(sram_dq_oe && sram_oe_n, "R8", "write drive", sram_dq_oe, 1);
      chk(!host_d_oe || (!host_rd_n && !host_sel), "R7", "host driver", host_d_oe, 0);
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    wait_neg(3);
    // R1 reset state
    chk(sram_ce_n && sram_oe_n && sram_we_n, "R1", "strobes in reset",
        {sram_ce_n, sram_oe_n, sram_we_n}, 7);
    chk(!sram_dq_oe && !host_d_oe, "R1", "drivers in reset", {sram_dq_oe, host_d_oe}, 0);
    rst_n = 1'b1;
    wait_neg(3);
    chk(sram_ce_n && !sram_dq_oe, "R1", "idle after reset", sram_ce_n, 1);
    // R1: pointer is 0 after reset, observed on first access
    data_wr(pat(0), 0, "R1");

    // R4 write sweep of the whole space, then R5 wrap back to 0
    for (int a = 1; a < DEPTH; a++) data_wr(pat(a), a, "R4");
    data_wr(pat(0), 0, "R5");

    // R3 throwaway read after load, then full read sweep, then R5 wrap
    load_addr(0);
    data_rd(0, "R3", HOLD);
    for (int a = 1; a < DEPTH; a++) data_rd(a, "R3", HOLD);
    data_rd(0, "R5", HOLD);

    // R2 over-long slice sequence: last three of 1..7 give 0x567
    for (int i = 1; i <= 7; i++) put_slice(4'(i));
    data_rd(12'h567, "R2", HOLD);

    // R7 read strobe in address mode does nothing
    host_sel = 1'b1; host_rd_n = 1'b0;
    wait_neg(HOLD);
    chk(sram_oe_n && sram_ce_n && !host_d_oe, "R7", "address-mode read",
        {sram_oe_n, sram_ce_n, host_d_oe}, 6);
    host_rd_n = 1'b1;
    wait_neg(GAP);
    data_rd(12'h568, "R7", HOLD);

    // R6 long strobes count once
    data_rd(12'h569, "R6", 40);
    data_rd(12'h56A, "R6", HOLD);
    data_wr(pat(12'h56B), 12'h56B, "R6");
    data_rd(12'h56C, "R6", HOLD);

    // R6 both strobes together: write wins, read dropped
    host_sel = 1'b0; host_d_i = pat(12'h56D);
    host_rd_n = 1'b0; host_wr_n = 1'b0;
    wait_neg(HOLD);
    chk(!sram_we_n && sram_oe_n && int'(sram_a) == 12'h56D, "R6", "simultaneous strobes",
        sram_a, 12'h56D);
    host_rd_n = 1'b1; host_wr_n = 1'b1;
    wait_neg(GAP);
    data_rd(12'h56E, "R6", HOLD);

    // R8 one-cycle drive tail after write strobe rises
    host_sel = 1'b0; host_d_i = pat(12'h56F); host_wr_n = 1'b0;
    wait_neg(HOLD);
    host_wr_n = 1'b1;
    wait_neg(1);
    while (!sram_we_n) wait_neg(1);
    chk(sram_dq_oe, "R8", "drive tail", sram_dq_oe, 1);
    wait_neg(1);
    chk(!sram_dq_oe, "R8", "drive released", sram_dq_oe, 0);
    wait_neg(GAP);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule